// File: doc/BRIEF.md
# Segmented Data Memory Address Unit

This unit sits between instruction decode and the data RAM of an 8-bit controller. Each cycle it takes one access request and turns it into a physical RAM address. The request is either a direct 8-bit address taken from the instruction or an indirect access through one of three pointers: two general data pointers (B and X) and the stack pointer (SP). An indirect access can step its pointer up or down by one once the access is done. A segment register widens the lower half of the 8-bit space, addresses 00 to 7F, into 256 banks of 128 bytes. The upper half, 80 to FF, always maps to one fixed region.

The unit also holds the sixteen-byte register window at F0 to FF. The pointers are stored in this window: X at FC, SP at FD, B at FE, and the segment register at FF. A plain write into the window loads a register, which also covers immediate loads. A decrement-and-test operation counts a window register down and raises a zero flag in the same cycle when the result is zero, so the sequencer can skip the next instruction. The RAM array, the ALU and the peripherals are outside this unit. Read data therefore comes back only for window addresses.

Top module: `dmau_top`

## Requirements
- R1: After reset, SP (window address FD) holds RAM_BYTES-17, which is 6F hex for 128 bytes and 2F hex for 64 bytes. Every other window byte, including X, B and the segment register, holds 00.
- R2: A logical address below 80 hex maps to the 16-bit physical address {0, S[7:0], addr[6:0]}, where S is the segment register.
- R3: A logical address at 80 hex or above maps to {1, 7'b0, addr[7:0]}, whatever the value of S.
- R4: When `indirect`=1, the logical address is the value of the selected pointer before any post-modify. The `ptr_sel` codes are 0=B, 1=X, 2=SP and 3=B. When `indirect`=0, the logical address is `dir_addr`.
- R5: `post_mod` codes are 0=none, 1=increment, 2=decrement and 3=none. A step applies only when `indirect`=1 and `op`!=0. It changes the selected pointer at the clock edge and wraps modulo 256.
- R6: `op` codes are 0=idle, 1=read, 2=write and 3=decrement-and-test. A write to a logical address F0 to FF loads that window byte with `wr_data`. `rd_data` shows the current value of the addressed window byte, and shows 00 for any address outside the window.
- R7: When a write or a decrement-and-test lands on a pointer's own window address, it takes priority over a post-modify of that pointer in the same cycle.
- R8: Decrement-and-test on a window address lowers that byte by one, modulo 256. `zero_flag` goes high in the same cycle exactly when the result is 00. Outside the window the operation changes nothing and `zero_flag` stays low.
- R9: `addr_in_range` is 1 for logical addresses 80 hex and above. For addresses below 80 hex it is 1 when S=0 and addr[6:0] < RAM_BYTES, or when 1 <= S <= EXT_SEGS. Otherwise it is 0.
- R10: An idle operation, or a write or decrement-and-test outside the window with no post-modify, leaves every window byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 2 | Operation: 0 idle, 1 read, 2 write, 3 decrement-and-test |
| indirect | input | 1 | 1 selects pointer addressing |
| ptr_sel | input | 2 | Pointer: 0 B, 1 X, 2 SP, 3 B |
| post_mod | input | 2 | Pointer step: 0 none, 1 up, 2 down, 3 none |
| dir_addr | input | 8 | Direct address from the instruction |
| wr_data | input | 8 | Data for window writes |
| phys_addr | output | 16 | Physical RAM address |
| addr_in_range | output | 1 | Physical address lies in populated memory |
| rd_data | output | 8 | Window byte at the logical address, else 00 |
| zero_flag | output | 1 | Decrement-and-test result is zero |

## Verification
The assertions treat `op`, `indirect`, `ptr_sel` and `post_mod` as stable and defined during each cycle, with no X values. They also rely on exactly one access per clock, so a window write and a pointer step are the only two ways a register can change. The bench changes its inputs only on the falling edge and holds them until the next one. It draws every code from its stated encoding, so reserved codes reach the unit only in the cycles that check they behave as their documented equivalents.

// File: rtl/dmau_pkg.sv
package dmau_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned SEGW  = 8;
  localparam int unsigned OFFW  = 7;
  localparam int unsigned PAW   = 1 + SEGW + OFFW;
  localparam int unsigned WIN_N = 16;
  localparam int unsigned IDXW  = $clog2(WIN_N);

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DSZ   = 2'd3
  } dm_op_e;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_INC  = 2'd1,
    PM_DEC  = 2'd2,
    PM_KEEP = 2'd3
  } pm_e;

  localparam logic [IDXW-1:0] IDX_X   = 4'd12;
  localparam logic [IDXW-1:0] IDX_SP  = 4'd13;
  localparam logic [IDXW-1:0] IDX_B   = 4'd14;
  localparam logic [IDXW-1:0] IDX_SEG = 4'd15;
  localparam logic [3:0]      WIN_HI  = 4'hF;

  function automatic logic [DW-1:0] step_ptr(input logic [DW-1:0] p, input logic [1:0] pm);
    case (pm)
      PM_INC:  return p + 8'd1;
      PM_DEC:  return p - 8'd1;
      default: return p;
    endcase
  endfunction

  function automatic logic [DW-1:0] dec_byte(input logic [DW-1:0] v);
    return v - 8'd1;
  endfunction

  function automatic logic [PAW-1:0] map_phys(input logic [SEGW-1:0] seg, input logic [DW-1:0] a);
    if (a[DW-1]) return {1'b1, {(PAW-1-DW){1'b0}}, a};
    else         return {1'b0, seg, a[OFFW-1:0]};
  endfunction
endpackage

// File: rtl/dmau_ptr_route.sv
module dmau_ptr_route
  import dmau_pkg::*;
(
  input  logic [1:0]      op,
  input  logic            indirect,
  input  logic [1:0]      ptr_sel,
  input  logic [1:0]      post_mod,
  input  logic [DW-1:0]   dir_addr,
  input  logic [DW-1:0]   ptr_b,
  input  logic [DW-1:0]   ptr_x,
  input  logic [DW-1:0]   ptr_sp,
  output logic [DW-1:0]   log_addr,
  output logic            pm_fire,
  output logic [IDXW-1:0] pm_idx,
  output logic [DW-1:0]   pm_val
);
  logic [DW-1:0] sel_val;

  always_comb begin
    case (ptr_sel)
      2'd1:    begin sel_val = ptr_x;  pm_idx = IDX_X;  end
      2'd2:    begin sel_val = ptr_sp; pm_idx = IDX_SP; end
      default: begin sel_val = ptr_b;  pm_idx = IDX_B;  end
    endcase
  end

  assign log_addr = indirect ? sel_val : dir_addr;
  assign pm_fire  = indirect && (op != OP_IDLE) &&
                    ((post_mod == PM_INC) || (post_mod == PM_DEC));
  assign pm_val   = step_ptr(sel_val, post_mod);
endmodule

// File: rtl/dmau_addr_map.sv
module dmau_addr_map
  import dmau_pkg::*;
#(
  parameter int RAM_BYTES = 128,
  parameter int EXT_SEGS  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SEGW-1:0] seg,
  input  logic [DW-1:0]   log_addr,
  output logic [PAW-1:0]  phys_addr,
  output logic            in_range,
  output logic            win_hit,
  output logic [IDXW-1:0] win_idx
);
  localparam int LOW_LIMIT = (RAM_BYTES > 128) ? 128 : RAM_BYTES;

  logic [31:0] low_off;
  logic [31:0] seg_num;

  assign low_off   = {25'd0, log_addr[OFFW-1:0]};
  assign seg_num   = {24'd0, seg};
  assign phys_addr = map_phys(seg, log_addr);
  assign win_hit   = (log_addr[DW-1:DW-4] == WIN_HI);
  assign win_idx   = log_addr[IDXW-1:0];

  always_comb begin
    if (log_addr[DW-1])       in_range = 1'b1;
    else if (seg_num == 32'd0) in_range = (low_off < 32'(LOW_LIMIT));
    else                       in_range = (seg_num <= 32'(EXT_SEGS));
  end

  a_r2_lower_half: assert property (@(posedge clk) disable iff (!rst_n)
    !log_addr[DW-1] |-> (!phys_addr[PAW-1] && !win_hit));
  a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    log_addr[DW-1] |-> (phys_addr[PAW-1] && phys_addr[DW-1:0] == log_addr &&
                        phys_addr[PAW-2:DW] == '0));
endmodule

// File: rtl/dmau_regwin.sv
module dmau_regwin
  import dmau_pkg::*;
#(
  parameter logic [7:0] SP_RST = 8'h6F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fire,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [DW-1:0]   wr_val,
  input  logic            pm_fire,
  input  logic [IDXW-1:0] pm_idx,
  input  logic [DW-1:0]   pm_val,
  input  logic [IDXW-1:0] rd_idx,
  output logic [DW-1:0]   rd_val,
  output logic [DW-1:0]   ptr_b,
  output logic [DW-1:0]   ptr_x,
  output logic [DW-1:0]   ptr_sp,
  output logic [SEGW-1:0] seg
);
  logic [DW-1:0]       regs [WIN_N];
  logic [WIN_N*DW-1:0] flat;

  for (genvar i = 0; i < WIN_N; i++) begin : g_entry
    localparam logic [DW-1:0] RST_V = (i == int'(IDX_SP)) ? SP_RST : '0;
    logic hit_wr;
    logic hit_pm;
    assign hit_wr = wr_fire && (wr_idx == IDXW'(i));
    assign hit_pm = pm_fire && (pm_idx == IDXW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs[i] <= RST_V;
      else if (hit_wr) regs[i] <= wr_val;
      else if (hit_pm) regs[i] <= pm_val;
    end

    assign flat[i*DW +: DW] = regs[i];
  end

  assign rd_val = regs[rd_idx];
  assign ptr_b  = regs[IDX_B];
  assign ptr_x  = regs[IDX_X];
  assign ptr_sp = regs[IDX_SP];
  assign seg    = regs[IDX_SEG];

  a_r7_write_over_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && pm_fire && wr_idx == pm_idx) |=> (regs[$past(wr_idx)] == $past(wr_val)));
  a_r10_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !pm_fire) |=> $stable(flat));
endmodule

// File: rtl/dmau_top.sv
module dmau_top
  import dmau_pkg::*;
#(
  parameter int RAM_BYTES = 128,
  parameter int EXT_SEGS  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  op,
  input  logic        indirect,
  input  logic [1:0]  ptr_sel,
  input  logic [1:0]  post_mod,
  input  logic [7:0]  dir_addr,
  input  logic [7:0]  wr_data,
  output logic [15:0] phys_addr,
  output logic        addr_in_range,
  output logic [7:0]  rd_data,
  output logic        zero_flag
);
  localparam logic [7:0] SP_RST = 8'(RAM_BYTES - 17);

  logic [DW-1:0]   ptr_b, ptr_x, ptr_sp, log_addr, pm_val, win_val, wr_val, dsz_res;
  logic [SEGW-1:0] seg;
  logic            pm_fire, win_hit, wr_fire;
  logic [IDXW-1:0] pm_idx, win_idx;

  dmau_ptr_route u_route (
    .op(op), .indirect(indirect), .ptr_sel(ptr_sel), .post_mod(post_mod),
    .dir_addr(dir_addr), .ptr_b(ptr_b), .ptr_x(ptr_x), .ptr_sp(ptr_sp),
    .log_addr(log_addr), .pm_fire(pm_fire), .pm_idx(pm_idx), .pm_val(pm_val)
  );

  dmau_addr_map #(.RAM_BYTES(RAM_BYTES), .EXT_SEGS(EXT_SEGS)) u_map (
    .clk(clk), .rst_n(rst_n), .seg(seg), .log_addr(log_addr),
    .phys_addr(phys_addr), .in_range(addr_in_range),
    .win_hit(win_hit), .win_idx(win_idx)
  );

  assign dsz_res   = dec_byte(win_val);
  assign wr_fire   = win_hit && ((op == OP_WRITE) || (op == OP_DSZ));
  assign wr_val    = (op == OP_DSZ) ? dsz_res : wr_data;
  assign rd_data   = win_hit ? win_val : 8'h00;
  assign zero_flag = win_hit && (op == OP_DSZ) && (dsz_res == 8'h00);

  dmau_regwin #(.SP_RST(SP_RST)) u_win (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_idx(win_idx), .wr_val(wr_val),
    .pm_fire(pm_fire), .pm_idx(pm_idx), .pm_val(pm_val),
    .rd_idx(win_idx), .rd_val(win_val),
    .ptr_b(ptr_b), .ptr_x(ptr_x), .ptr_sp(ptr_sp), .seg(seg)
  );

  a_r5_b_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_fire && pm_idx == IDX_B && post_mod == PM_INC && !(wr_fire && win_idx == IDX_B))
    |=> (ptr_b == $past(ptr_b) + 8'd1));
  a_r5_sp_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_fire && pm_idx == IDX_SP && post_mod == PM_DEC && !(wr_fire && win_idx == IDX_SP))
    |=> (ptr_sp == $past(ptr_sp) - 8'd1));
  a_r8_zero_only_dsz: assert property (@(posedge clk) disable iff (!rst_n)
    zero_flag |-> (op == OP_DSZ && win_hit));
  a_r8_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_flag && !pm_fire) |=> (u_win.regs[$past(win_idx)] == 8'h00));
  a_r1_sp_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (ptr_sp == SP_RST));
endmodule

// File: tb/dmau_top_test.sv
`timescale 1ns/1ps
module dmau_top_test;
  localparam int RAM = 128;
  localparam int EXT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op = 2'd0, ptr_sel = 2'd0, post_mod = 2'd0;
  logic       indirect = 1'b0;
  logic [7:0] dir_addr = 8'd0, wr_data = 8'd0;
  logic [15:0] phys_addr;
  logic        addr_in_range, zero_flag;
  logic [7:0]  rd_data;

  dmau_top #(.RAM_BYTES(RAM), .EXT_SEGS(EXT)) uut (
    .clk(clk), .rst_n(rst_n), .op(op), .indirect(indirect), .ptr_sel(ptr_sel),
    .post_mod(post_mod), .dir_addr(dir_addr), .wr_data(wr_data),
    .phys_addr(phys_addr), .addr_in_range(addr_in_range),
    .rd_data(rd_data), .zero_flag(zero_flag)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    phys;
    int    rng;
    int    rd;
    int    z;
    string tag;
  } exp_t;

  exp_t q[$];
  int   mreg[16];
  int   n_vec = 0, n_bad = 0;
  bit   reported = 0;
  event smp;

  task automatic chk(string tag, string what, int act, int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      @(smp);
      e = q.pop_front();
      n_vec++;
      chk(e.tag, "phys_addr", int'(phys_addr), e.phys);
      chk(e.tag, "addr_in_range", int'(addr_in_range), e.rng);
      chk(e.tag, "rd_data", int'(rd_data), e.rd);
      chk(e.tag, "zero_flag", int'(zero_flag), e.z);
    end
  end

  function automatic int ptr_of(int sel);
    if (sel == 1) return mreg[12];
    if (sel == 2) return mreg[13];
    return mreg[14];
  endfunction

  task automatic apply(int o, int ind, int sel, int pm, int a, int d, string tag);
    exp_t e;
    int la, low, s, hit, idx, pidx;
    @(negedge clk);
    op = 2'(o); indirect = 1'(ind); ptr_sel = 2'(sel); post_mod = 2'(pm);
    dir_addr = 8'(a); wr_data = 8'(d);
    la  = (ind != 0) ? ptr_of(sel) : a;
    s   = mreg[15];
    low = la % 128;
    hit = (la >= 240);
    idx = la - 240;
    e.phys = (la >= 128) ? 32768 + la : s * 128 + low;
    if (la >= 128)   e.rng = 1;
    else if (s == 0) e.rng = (low < RAM) ? 1 : 0;
    else             e.rng = (s <= EXT) ? 1 : 0;
    e.rd  = hit ? mreg[idx] : 0;
    e.z   = (o == 3 && hit && e.rd == 1) ? 1 : 0;
    e.tag = tag;
    q.push_back(e);
    #1 -> smp;
    @(posedge clk);
    if (ind != 0 && o != 0 && (pm == 1 || pm == 2)) begin
      pidx = (sel == 1) ? 12 : (sel == 2) ? 13 : 14;
      mreg[pidx] = (pm == 1) ? (mreg[pidx] + 1) % 256 : (mreg[pidx] + 255) % 256;
    end
    if (hit && o == 2) mreg[idx] = d;
    if (hit && o == 3) mreg[idx] = (e.rd + 255) % 256;
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin : driver
    for (int i = 0; i < 16; i++) mreg[i] = 0;
    mreg[13] = RAM - 17;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset values read through the window
    apply(1, 0, 0, 0, 8'hFD, 0, "R1");
    apply(1, 0, 0, 0, 8'hFC, 0, "R1");
    apply(1, 0, 0, 0, 8'hFE, 0, "R1");
    apply(1, 0, 0, 0, 8'hFF, 0, "R1");
    apply(1, 0, 0, 0, 8'hF0, 0, "R1");
    // R2 / R9: segment 0, then other segments
    apply(1, 0, 0, 0, 8'h15, 0, "R2");
    apply(1, 0, 0, 0, 8'h7F, 0, "R9");
    apply(2, 0, 0, 0, 8'hFF, 8'h05, "R6");
    apply(1, 0, 0, 0, 8'h23, 0, "R2");
    apply(1, 0, 0, 0, 8'h23, 0, "R9");
    // R3: upper half ignores S
    apply(1, 0, 0, 0, 8'h90, 0, "R3");
    apply(1, 0, 0, 0, 8'hF4, 0, "R3");
    apply(2, 0, 0, 0, 8'hFF, 8'h02, "R9");
    apply(1, 0, 0, 0, 8'h40, 0, "R9");
    // R4 / R5: B step up, X wraps down then up
    apply(2, 0, 0, 0, 8'hFE, 8'h40, "R6");
    apply(1, 1, 0, 1, 0, 0, "R4");
    apply(1, 0, 0, 0, 8'hFE, 0, "R5");
    apply(1, 1, 1, 2, 0, 0, "R4");
    apply(1, 0, 0, 0, 8'hFC, 0, "R5");
    apply(1, 1, 1, 1, 0, 0, "R5");
    apply(1, 0, 0, 0, 8'hFC, 0, "R5");
    apply(2, 1, 2, 2, 0, 8'h33, "R4");
    apply(1, 0, 0, 0, 8'hFD, 0, "R5");
    apply(1, 1, 3, 1, 0, 0, "R4");
    apply(1, 1, 0, 3, 0, 0, "R5");
    apply(1, 0, 0, 0, 8'hFE, 0, "R5");
    // R7: B points at itself, write wins over step
    apply(2, 0, 0, 0, 8'hFE, 8'hFE, "R7");
    apply(2, 1, 0, 1, 0, 8'h77, "R7");
    apply(1, 0, 0, 0, 8'hFE, 0, "R7");
    apply(2, 0, 0, 0, 8'hFC, 8'hFC, "R7");
    apply(3, 1, 1, 2, 0, 0, "R7");
    apply(1, 0, 0, 0, 8'hFC, 0, "R7");
    // R8: count down to zero and wrap
    apply(2, 0, 0, 0, 8'hF3, 8'h02, "R6");
    apply(3, 0, 0, 0, 8'hF3, 0, "R8");
    apply(3, 0, 0, 0, 8'hF3, 0, "R8");
    apply(1, 0, 0, 0, 8'hF3, 0, "R8");
    apply(3, 0, 0, 0, 8'hF3, 0, "R8");
    apply(1, 0, 0, 0, 8'hF3, 0, "R8");
    apply(3, 0, 0, 0, 8'h20, 0, "R8");
    // R10: no effect outside window or when idle
    apply(2, 0, 0, 0, 8'h20, 8'h99, "R10");
    apply(0, 1, 0, 1, 0, 8'h55, "R10");
    apply(0, 0, 0, 0, 8'hF3, 8'h11, "R10");
    for (int i = 0; i < 16; i++) apply(1, 0, 0, 0, 240 + i, 0, "R10");
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int a;
      a = ($urandom % 2 == 0) ? (240 + $urandom % 16) : int'($urandom % 256);
      apply(int'($urandom % 4), int'($urandom % 2), int'($urandom % 3),
            int'($urandom % 4), a, int'($urandom % 256), "R6");
    end
    @(negedge clk);
    finish_run();
  end
endmodule